// File: doc/BRIEF.md
# Vector Contiguous Load Decoder

This block takes one 32-bit instruction word from the scalable-vector contiguous load class, together with the values already read from the two scalar registers that the word names. It returns the decoded fields and the starting byte address of the access. Those fields are the destination vector register, the governing predicate, the base and offset register indices, the 4-bit immediate, the data type and the structure count. The data type is a 4-bit code that sets the memory size, the element size and the sign extension together, so the block also expands it into those three attributes. The vector length in bytes is fixed by a parameter, and it sets how the immediate forms scale their offset.

The block works as a registered request/response unit. A request captured on one rising edge produces a response one cycle later. A two-state machine tracks this. `S_IDLE` means no response is being presented. `S_RESP` means the response registers hold a fresh result. A cycle with `req_valid` high takes the machine to `S_RESP` from either state. A cycle with `req_valid` low takes it to `S_IDLE`. Requests may therefore arrive back to back. Words that do not fit any of the four recognised forms set the illegal flag, and every other field of that response reads zero.

Top module: `vld_dec`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0, and all response fields are 0 until the first request is captured.
- R2: A request with `req_valid` high at a rising edge gives `rsp_valid` high after that edge for exactly one cycle, unless another request follows. A cycle without a request gives `rsp_valid` low after the next edge.
- R3: On any legal word, the destination is bits [4:0], the base register index is bits [9:5], and the predicate index is bits [12:10] (3 bits, predicates 0 to 7).
- R4: Bits [15:13] = 010 select the register-offset single form. The data type is bits [24:21], the offset index is bits [20:16], the structure count minus one is 0, `rsp_imm_form` is 0 and `rsp_imm` is 0.
- R5: Bits [15:13] = 101 with bit 20 = 0 select the immediate single form. The data type is bits [24:21], `rsp_imm` is bits [19:16] (signed two's complement), `rsp_imm_form` is 1, and the offset index is 0.
- R6: Bits [15:13] = 110 (register offset) and 111 (immediate, bit 20 must be 0) select the multi-structure forms. The structure count minus one is bits [22:21], and the memory size code m in bits [24:23] gives the data type 5·m (0, 5, 10 or 15), which is unsigned with element size equal to memory size.
- R7: For data types 0 to 15, the log2 memory size is 0,0,0,0,2,1,1,1,1,1,2,2,0,0,0,3 and the log2 element size is 0,1,2,3,3,1,2,3,3,2,2,3,3,2,1,3. The sign flag is set only for types 4, 8, 9, 12, 13 and 14.
- R8: In the register-offset forms, the address is base + offset × ((nreg+1) << msz).
- R9: In the immediate forms, the address is base + ((sext(imm) × (VL_BYTES >> esz) × (nreg+1)) << msz).
- R10: A word is illegal when bits [31:25] ≠ 1010010, when bits [15:13] are not 010, 101, 110 or 111, or when bit 20 is 1 in the 101 or 111 forms. An illegal word sets `rsp_illegal`, and every other response field is 0.
- R11: In the register-offset forms (010, 110), an offset index of 31 makes the word illegal, with the same zeroed response as R10.
- R12: Address arithmetic is 64-bit and wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_insn | input | 32 | Instruction word |
| req_base | input | 64 | Value of the base scalar register |
| req_offset | input | 64 | Value of the offset scalar register |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Word not a legal contiguous load |
| rsp_dst | output | 5 | Destination vector register |
| rsp_pred | output | 3 | Governing predicate register |
| rsp_base_idx | output | 5 | Base register index |
| rsp_off_idx | output | 5 | Offset register index (register forms) |
| rsp_imm | output | 4 | Signed immediate (immediate forms) |
| rsp_imm_form | output | 1 | 1 for the immediate forms |
| rsp_dtype | output | 4 | Data type code |
| rsp_nreg | output | 2 | Structure count minus one |
| rsp_msz | output | 2 | log2 memory element bytes |
| rsp_esz | output | 2 | log2 register element bytes |
| rsp_signed | output | 1 | Sign-extend loaded elements |
| rsp_addr | output | 64 | Starting byte address |

## Verification
The bench tries offset index 31 in both register-offset forms. A decoder that skipped that check would return a valid-looking address that uses the zero register. It also sets bit 20 in the immediate forms and uses unused values of bits [15:13]. A loose form match would accept these words and return nonzero fields next to the illegal flag. It uses a negative immediate at several element sizes, a three-structure load and a base near 2^64. A zero-extended immediate, a missing element-count factor, or a narrower adder would each give the wrong address. Back-to-back requests followed by an idle cycle catch a response strobe that sticks high or skips a request.

// File: rtl/vld_pkg.sv
package vld_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } vld_state_e;

    typedef struct packed {
        logic       illegal;
        logic [4:0] dst;
        logic [2:0] pred;
        logic [4:0] base_idx;
        logic [4:0] off_idx;
        logic [3:0] imm;
        logic       imm_form;
        logic [3:0] dtype;
        logic [1:0] nreg;
    } vld_fields_t;

    typedef struct packed {
        logic [1:0] msz;
        logic [1:0] esz;
        logic       sgn;
    } vld_props_t;

    localparam logic [6:0] VLD_MAJOR = 7'b1010010;

endpackage

// File: rtl/vld_field_decode.sv
module vld_field_decode
    import vld_pkg::*;
(
    input  logic [31:0] insn,
    output vld_fields_t fields
);
    logic [2:0]  form;
    logic        bad;
    vld_fields_t raw;

    assign form = insn[15:13];

    always_comb begin
        raw          = '0;
        bad          = (insn[31:25] != VLD_MAJOR);
        raw.dst      = insn[4:0];
        raw.base_idx = insn[9:5];
        raw.pred     = insn[12:10];
        case (form)
            3'b010: begin
                raw.dtype   = insn[24:21];
                raw.off_idx = insn[20:16];
                if (insn[20:16] == 5'd31) bad = 1'b1;
            end
            3'b101: begin
                raw.dtype    = insn[24:21];
                raw.imm      = insn[19:16];
                raw.imm_form = 1'b1;
                if (insn[20]) bad = 1'b1;
            end
            3'b110: begin
                raw.dtype   = {insn[24:23], insn[24:23]};
                raw.nreg    = insn[22:21];
                raw.off_idx = insn[20:16];
                if (insn[20:16] == 5'd31) bad = 1'b1;
            end
            3'b111: begin
                raw.dtype    = {insn[24:23], insn[24:23]};
                raw.nreg     = insn[22:21];
                raw.imm      = insn[19:16];
                raw.imm_form = 1'b1;
                if (insn[20]) bad = 1'b1;
            end
            default: bad = 1'b1;
        endcase
        if (bad) begin
            fields         = '0;
            fields.illegal = 1'b1;
        end else begin
            fields = raw;
        end
    end
endmodule

// File: rtl/vld_dtype_props.sv
module vld_dtype_props
    import vld_pkg::*;
(
    input  logic [3:0] dtype,
    output vld_props_t props
);
    always_comb begin
        props = '0;
        case (dtype)
            4'd0:  begin props.msz = 2'd0; props.esz = 2'd0; props.sgn = 1'b0; end
            4'd1:  begin props.msz = 2'd0; props.esz = 2'd1; props.sgn = 1'b0; end
            4'd2:  begin props.msz = 2'd0; props.esz = 2'd2; props.sgn = 1'b0; end
            4'd3:  begin props.msz = 2'd0; props.esz = 2'd3; props.sgn = 1'b0; end
            4'd4:  begin props.msz = 2'd2; props.esz = 2'd3; props.sgn = 1'b1; end
            4'd5:  begin props.msz = 2'd1; props.esz = 2'd1; props.sgn = 1'b0; end
            4'd6:  begin props.msz = 2'd1; props.esz = 2'd2; props.sgn = 1'b0; end
            4'd7:  begin props.msz = 2'd1; props.esz = 2'd3; props.sgn = 1'b0; end
            4'd8:  begin props.msz = 2'd1; props.esz = 2'd3; props.sgn = 1'b1; end
            4'd9:  begin props.msz = 2'd1; props.esz = 2'd2; props.sgn = 1'b1; end
            4'd10: begin props.msz = 2'd2; props.esz = 2'd2; props.sgn = 1'b0; end
            4'd11: begin props.msz = 2'd2; props.esz = 2'd3; props.sgn = 1'b0; end
            4'd12: begin props.msz = 2'd0; props.esz = 2'd3; props.sgn = 1'b1; end
            4'd13: begin props.msz = 2'd0; props.esz = 2'd2; props.sgn = 1'b1; end
            4'd14: begin props.msz = 2'd0; props.esz = 2'd1; props.sgn = 1'b1; end
            default: begin props.msz = 2'd3; props.esz = 2'd3; props.sgn = 1'b0; end
        endcase
    end
endmodule

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
    parameter int VL_BYTES = 32,
    parameter int AW       = 64
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          imm_form,
    input  logic [3:0]    imm,
    input  logic [1:0]    nreg,
    input  logic [1:0]    msz,
    input  logic [1:0]    esz,
    output logic [AW-1:0] addr
);
    localparam int VL_LOG2 = $clog2(VL_BYTES);

    logic [2:0]    regs;
    logic [5:0]    ss_factor;
    logic [AW-1:0] ss_prod;
    logic [AW-1:0] imm_ext;
    logic [AW-1:0] imm_cnt;
    logic [3:0]    si_shift;
    logic [AW-1:0] si_offs;

    always_comb begin
        regs      = {1'b0, nreg} + 3'd1;
        ss_factor = {3'b000, regs} << msz;
        ss_prod   = offset * {{(AW-6){1'b0}}, ss_factor};
        imm_ext   = {{(AW-4){imm[3]}}, imm};
        imm_cnt   = imm_ext * {{(AW-3){1'b0}}, regs};
        si_shift  = 4'(VL_LOG2) - {2'b00, esz} + {2'b00, msz};
        si_offs   = imm_cnt << si_shift;
        addr      = base + (imm_form ? si_offs : ss_prod);
    end
endmodule

// File: rtl/vld_dec.sv
module vld_dec
    import vld_pkg::*;
#(
    parameter int VL_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_insn,
    input  logic [63:0] req_base,
    input  logic [63:0] req_offset,
    output logic        rsp_valid,
    output logic        rsp_illegal,
    output logic [4:0]  rsp_dst,
    output logic [2:0]  rsp_pred,
    output logic [4:0]  rsp_base_idx,
    output logic [4:0]  rsp_off_idx,
    output logic [3:0]  rsp_imm,
    output logic        rsp_imm_form,
    output logic [3:0]  rsp_dtype,
    output logic [1:0]  rsp_nreg,
    output logic [1:0]  rsp_msz,
    output logic [1:0]  rsp_esz,
    output logic        rsp_signed,
    output logic [63:0] rsp_addr
);
    localparam int AW = 64;

    vld_state_e  state_q, state_d;
    vld_fields_t dec_f, f_q;
    vld_props_t  dec_p, p_q;
    logic [AW-1:0] dec_addr, addr_q;

    vld_field_decode u_fields (
        .insn   (req_insn),
        .fields (dec_f)
    );

    vld_dtype_props u_props (
        .dtype (dec_f.dtype),
        .props (dec_p)
    );

    vld_addr_gen #(.VL_BYTES(VL_BYTES), .AW(AW)) u_addr (
        .base     (req_base),
        .offset   (req_offset),
        .imm_form (dec_f.imm_form),
        .imm      (dec_f.imm),
        .nreg     (dec_f.nreg),
        .msz      (dec_p.msz),
        .esz      (dec_p.esz),
        .addr     (dec_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP: state_d = req_valid ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            p_q    <= '0;
            addr_q <= '0;
        end else if (req_valid) begin
            f_q    <= dec_f;
            p_q    <= dec_f.illegal ? '0 : dec_p;
            addr_q <= dec_f.illegal ? '0 : dec_addr;
        end
    end

    assign rsp_valid    = (state_q == S_RESP);
    assign rsp_illegal  = f_q.illegal;
    assign rsp_dst      = f_q.dst;
    assign rsp_pred     = f_q.pred;
    assign rsp_base_idx = f_q.base_idx;
    assign rsp_off_idx  = f_q.off_idx;
    assign rsp_imm      = f_q.imm;
    assign rsp_imm_form = f_q.imm_form;
    assign rsp_dtype    = f_q.dtype;
    assign rsp_nreg     = f_q.nreg;
    assign rsp_msz      = p_q.msz;
    assign rsp_esz      = p_q.esz;
    assign rsp_signed   = p_q.sgn;
    assign rsp_addr     = addr_q;

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_addr == '0 && rsp_dtype == '0 &&
            rsp_dst == '0 && rsp_pred == '0 && rsp_signed == 1'b0 && rsp_nreg == '0));

    p_rm31_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_insn[31:25] == VLD_MAJOR && req_insn[14:13] == 2'b10 &&
         req_insn[20:16] == 5'd31) |=> rsp_illegal);

    p_esz_covers_msz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal) |-> (rsp_esz >= rsp_msz));

    p_multi_unsigned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal && rsp_nreg != 2'd0) |-> (!rsp_signed && rsp_esz == rsp_msz));

endmodule

// File: tb/vld_dec_test.sv
`timescale 1ns/1ps
module vld_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_insn = '0;
    logic [63:0] req_base = '0;
    logic [63:0] req_offset = '0;
    logic        rsp_valid, rsp_illegal, rsp_imm_form, rsp_signed;
    logic [4:0]  rsp_dst, rsp_base_idx, rsp_off_idx;
    logic [2:0]  rsp_pred;
    logic [3:0]  rsp_imm, rsp_dtype;
    logic [1:0]  rsp_nreg, rsp_msz, rsp_esz;
    logic [63:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    vld_dec #(.VL_BYTES(32)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
        .req_base(req_base), .req_offset(req_offset), .rsp_valid(rsp_valid),
        .rsp_illegal(rsp_illegal), .rsp_dst(rsp_dst), .rsp_pred(rsp_pred),
        .rsp_base_idx(rsp_base_idx), .rsp_off_idx(rsp_off_idx), .rsp_imm(rsp_imm),
        .rsp_imm_form(rsp_imm_form), .rsp_dtype(rsp_dtype), .rsp_nreg(rsp_nreg),
        .rsp_msz(rsp_msz), .rsp_esz(rsp_esz), .rsp_signed(rsp_signed), .rsp_addr(rsp_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] w_reg(input logic [3:0] dt, input logic [4:0] rm,
                                          input logic [2:0] pg, input logic [4:0] rn,
                                          input logic [4:0] rd);
        return {7'b1010010, dt, rm, 3'b010, pg, rn, rd};
    endfunction

    function automatic logic [31:0] w_imm(input logic [3:0] dt, input logic [3:0] im,
                                          input logic [2:0] pg, input logic [4:0] rn,
                                          input logic [4:0] rd);
        return {7'b1010010, dt, 1'b0, im, 3'b101, pg, rn, rd};
    endfunction

    task automatic issue(input logic [31:0] w, input logic [63:0] b, input logic [63:0] o);
        @(negedge clk);
        req_valid  = 1'b1;
        req_insn   = w;
        req_base   = b;
        req_offset = o;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [4:0] dst, input logic [2:0] pred,
                             input logic [4:0] bidx, input logic [4:0] oidx,
                             input logic [3:0] imm, input logic immf, input logic [3:0] dt,
                             input logic [1:0] nreg, input logic [1:0] msz,
                             input logic [1:0] esz, input logic sgn, input logic [63:0] addr);
        check({tag, " valid R2"},   64'(rsp_valid), 64'd1);
        check({tag, " illegal"},    64'(rsp_illegal), 64'd0);
        check({tag, " dst R3"},     64'(rsp_dst), 64'(dst));
        check({tag, " pred R3"},    64'(rsp_pred), 64'(pred));
        check({tag, " base R3"},    64'(rsp_base_idx), 64'(bidx));
        check({tag, " offidx"},     64'(rsp_off_idx), 64'(oidx));
        check({tag, " imm"},        64'(rsp_imm), 64'(imm));
        check({tag, " immform"},    64'(rsp_imm_form), 64'(immf));
        check({tag, " dtype"},      64'(rsp_dtype), 64'(dt));
        check({tag, " nreg"},       64'(rsp_nreg), 64'(nreg));
        check({tag, " msz R7"},     64'(rsp_msz), 64'(msz));
        check({tag, " esz R7"},     64'(rsp_esz), 64'(esz));
        check({tag, " signed R7"},  64'(rsp_signed), 64'(sgn));
        check({tag, " addr"},       rsp_addr, addr);
    endtask

    task automatic expect_bad(input string tag);
        check({tag, " valid"},   64'(rsp_valid), 64'd1);
        check({tag, " illegal"}, 64'(rsp_illegal), 64'd1);
        check({tag, " zero fields"},
              64'({rsp_dst, rsp_pred, rsp_base_idx, rsp_off_idx, rsp_imm, rsp_imm_form,
                   rsp_dtype, rsp_nreg, rsp_msz, rsp_esz, rsp_signed}), 64'd0);
        check({tag, " zero addr"}, rsp_addr, 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid low in reset", 64'(rsp_valid), 64'd0);
        check("R1 addr zero", rsp_addr, 64'd0);
        check("R1 illegal zero", 64'(rsp_illegal), 64'd0);
    endtask

    task automatic t_reg_single();
        issue(w_reg(4'd5, 5'd9, 3'd5, 5'd7, 5'd3), 64'h1000, 64'h10);
        expect_ok("R4 R8 dtype5", 5'd3, 3'd5, 5'd7, 5'd9, 4'd0, 1'b0, 4'd5, 2'd0,
                  2'd1, 2'd1, 1'b0, 64'h1020);
        issue(w_reg(4'd4, 5'd2, 3'd7, 5'd31, 5'd31), 64'h100, 64'd3);
        expect_ok("R4 R7 R8 dtype4 signed", 5'd31, 3'd7, 5'd31, 5'd2, 4'd0, 1'b0, 4'd4,
                  2'd0, 2'd2, 2'd3, 1'b1, 64'h10C);
    endtask

    task automatic t_imm_single();
        issue(w_imm(4'd12, 4'hF, 3'd1, 5'd4, 5'd8), 64'h2000, 64'hDEAD);
        expect_ok("R5 R9 neg imm dtype12", 5'd8, 3'd1, 5'd4, 5'd0, 4'hF, 1'b1, 4'd12,
                  2'd0, 2'd0, 2'd3, 1'b1, 64'h1FFC);
        issue(w_imm(4'd15, 4'd7, 3'd0, 5'd0, 5'd0), 64'h0, 64'h5555);
        expect_ok("R5 R9 imm7 dtype15", 5'd0, 3'd0, 5'd0, 5'd0, 4'd7, 1'b1, 4'd15,
                  2'd0, 2'd3, 2'd3, 1'b0, 64'hE0);
    endtask

    task automatic t_multi();
        // 110 form, msz code 2 -> dtype 10, nreg 2: base + off*12
        issue({7'b1010010, 2'd2, 2'd2, 5'd6, 3'b110, 3'd2, 5'd1, 5'd12}, 64'h40, 64'd5);
        expect_ok("R6 R8 three-struct reg", 5'd12, 3'd2, 5'd1, 5'd6, 4'd0, 1'b0, 4'd10,
                  2'd2, 2'd2, 2'd2, 1'b0, 64'h7C);
        // 111 form, msz code 1 -> dtype 5, nreg 3, imm -2: (-2*16*4)<<1 = -256
        issue({7'b1010010, 2'd1, 2'd3, 1'b0, 4'hE, 3'b111, 3'd6, 5'd2, 5'd20}, 64'h1000, 64'd0);
        expect_ok("R6 R9 four-struct imm", 5'd20, 3'd6, 5'd2, 5'd0, 4'hE, 1'b1, 4'd5,
                  2'd3, 2'd1, 2'd1, 1'b0, 64'hF00);
    endtask

    task automatic t_illegal();
        issue(w_reg(4'd5, 5'd31, 3'd1, 5'd1, 5'd1), 64'h1000, 64'h10);
        expect_bad("R11 single rm31");
        issue({7'b1010010, 2'd3, 2'd1, 5'd31, 3'b110, 3'd1, 5'd1, 5'd1}, 64'h1000, 64'h10);
        expect_bad("R11 multi rm31");
        issue(w_reg(4'd5, 5'd2, 3'd1, 5'd1, 5'd1) ^ 32'h8000_0000, 64'h1000, 64'h10);
        expect_bad("R10 major bits");
        issue(w_imm(4'd0, 4'd1, 3'd1, 5'd1, 5'd1) | 32'h0010_0000, 64'h1000, 64'h10);
        expect_bad("R10 bit20 imm single");
        issue({7'b1010010, 2'd0, 2'd1, 1'b1, 4'd1, 3'b111, 3'd1, 5'd1, 5'd1}, 64'h1000, 64'h10);
        expect_bad("R10 bit20 imm multi");
        issue({7'b1010010, 4'd0, 5'd2, 3'b000, 3'd1, 5'd1, 5'd1}, 64'h1000, 64'h10);
        expect_bad("R10 form 000");
    endtask

    task automatic t_wrap();
        issue(w_reg(4'd0, 5'd3, 3'd0, 5'd1, 5'd2), 64'hFFFF_FFFF_FFFF_FFF0, 64'h10);
        expect_ok("R12 wrap", 5'd2, 3'd0, 5'd1, 5'd3, 4'd0, 1'b0, 4'd0, 2'd0,
                  2'd0, 2'd0, 1'b0, 64'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1;
        req_insn  = w_reg(4'd0, 5'd1, 3'd0, 5'd0, 5'd0);
        req_base  = 64'h100;
        req_offset = 64'd1;
        @(negedge clk);
        check("R2 first of pair valid", 64'(rsp_valid), 64'd1);
        check("R2 first of pair addr", rsp_addr, 64'h101);
        req_insn  = w_reg(4'd15, 5'd1, 3'd0, 5'd0, 5'd0);
        req_offset = 64'd2;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 second of pair valid", 64'(rsp_valid), 64'd1);
        check("R2 second of pair addr", rsp_addr, 64'h110);
        @(negedge clk);
        check("R2 idle drops valid", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", 64'(rsp_valid), 64'd0);
        t_reg_single();
        t_imm_single();
        t_multi();
        t_illegal();
        t_wrap();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule